// File: doc/BRIEF.md
# JTAG Byte Shift Engine

This block turns byte-wide host commands into JTAG pin activity. A shift command serialises one byte onto TDI, least significant bit first, with exactly eight TCK pulses. In read-write mode it also collects TDO during the pulses and returns the collected byte. In write-only mode TDO is ignored. A pin command skips shifting and drives TCK, TMS, TDI and an active-low enable/indicator line straight from chosen bits of the data byte. Its readback form also returns the present TDO level.

TCK timing comes from a free-running clock enable. The enable fires once every `TICK_DIV` system cycles. The high and low phases of TCK last `HIGH_TICKS` and `LOW_TICKS` enables. With the defaults and a 48 MHz clock this is a 12 MHz enable, a 2.4 MHz TCK and a 20 % high phase. TDO passes through a two-flop synchroniser, so `TICK_DIV` must be at least 3. TMS is changed only by pin commands.

The controller has four states.
- `S_IDLE` is the only state that accepts a command. It moves to `S_LOW` on a shift command (start) and to `S_DONE` on a pin command (apply).
- In `S_LOW`, on the first enable of the low phase the block samples TDO and drives the next TDI bit (capture). It moves to `S_HIGH` on the last low enable (rise).
- `S_HIGH` moves back to `S_LOW` on its last enable while bits remain (fall). After the eighth bit it moves to `S_DONE` (finish).
- `S_DONE` lasts one cycle and returns to `S_IDLE` (release).

Top module: `jtag_byte_shifter`

## Requirements
- R1: While `rst` is high and after it is released: `jtag_tck`, `jtag_tms` and `jtag_tdi` are 0, `jtag_oe_n` is 1, `cmd_ready` is 1, `done` and `rsp_valid` are 0, and `rsp_data` is 0x00.
- R2: A shift command (`cmd_op` 00 or 01) produces exactly 8 rising edges on `jtag_tck`. At the k-th rising edge (k = 0..7), `jtag_tdi` equals `cmd_data[k]`.
- R3: During a shift command, `jtag_tdi` changes only while `jtag_tck` is low. `jtag_tck` is low in the cycle where `done` is high.
- R4: Between the pulses of a shift command, each TCK high phase lasts `HIGH_TICKS*TICK_DIV` cycles and each low phase lasts `LOW_TICKS*TICK_DIV` cycles. With the defaults these are 4 and 16 cycles.
- R5: In read-write mode (`cmd_op` 01), TDO is sampled once in each low phase, one enable after TCK falls and before TDI is updated. The sample is shifted into bit 7 of a right-shifting register. In the `done` cycle, `rsp_data` holds the 8 samples, with the first sample in bit 0, and `rsp_valid` is 1.
- R6: In write-only mode (`cmd_op` 00), `rsp_valid` stays 0 and `rsp_data` keeps its previous value whatever TDO does.
- R7: A pin command (`cmd_op` 10) drives the pins from the data byte: bit 0 to `jtag_tck`, bit 1 to `jtag_tms`, bit 4 to `jtag_tdi`, and the inverse of bit 5 to `jtag_oe_n`. The other data bits have no effect. `done` follows one cycle after acceptance, with `rsp_valid` 0.
- R8: A pin command with readback (`cmd_op` 11) drives the pins as in R7. With `done` it also returns `rsp_data` = 0x02 OR the synchronised TDO level in bit 0, with `rsp_valid` 1.
- R9: `jtag_tms` changes only in the cycle after a pin command is accepted. Shift commands leave it unchanged.
- R10: A command is accepted only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the cycle after acceptance through the one-cycle `done` pulse, and high again in the cycle after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 00 shift write-only, 01 shift read-write, 10 pin set, 11 pin set with readback |
| cmd_data | input | 8 | Byte to shift, or pin image |
| rsp_data | output | 8 | Result byte |
| rsp_valid | output | 1 | `rsp_data` updated, coincides with `done` |
| done | output | 1 | One-cycle completion pulse |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Test data to the device |
| jtag_oe_n | output | 1 | Active-low enable/indicator |
| jtag_tdo | input | 1 | Test data from the device, asynchronous |

## Verification
The completion of a shift command and the arrival of the next command can fall in the same cycle. The bench holds a TMS-changing pin command on `cmd_valid` while a read-write shift is still running. In the `done` cycle of the shift, it requires `cmd_ready` low, TMS untouched and the shifted-in byte present. In the following cycles, it requires the pin command to be accepted and TMS to change one cycle after acceptance. A held `cmd_valid` stream of pin commands is then counted to show exactly one acceptance per two cycles, with `done` and `cmd_ready` never high together.

// File: rtl/jbs_pkg.sv
package jbs_pkg;

    localparam int BYTE_W  = 8;
    localparam int BIT_W   = $clog2(BYTE_W);

    // bit positions of the pin image
    localparam int PIN_TCK = 0;
    localparam int PIN_TMS = 1;
    localparam int PIN_TDI = 4;
    localparam int PIN_OE  = 5;

    localparam logic [BYTE_W-1:0] RB_BASE = 8'h02;

    typedef enum logic [1:0] {
        OP_SHIFT_WO = 2'b00,
        OP_SHIFT_RW = 2'b01,
        OP_PIN      = 2'b10,
        OP_PIN_RD   = 2'b11
    } jbs_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOW,
        S_HIGH,
        S_DONE
    } jbs_state_e;

endpackage

// File: rtl/jbs_tick_gen.sv
module jbs_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == DIV_LAST);
endmodule

// File: rtl/jbs_sync.sv
module jbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/jtag_byte_shifter.sv
module jtag_byte_shifter
    import jbs_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter int HIGH_TICKS  = 1,
    parameter int LOW_TICKS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              rsp_valid,
    output logic              done,
    output logic              jtag_tck,
    output logic              jtag_tms,
    output logic              jtag_tdi,
    output logic              jtag_oe_n,
    input  logic              jtag_tdo
);
    localparam int PH_MAX = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS;
    localparam int CNT_W  = $clog2(PH_MAX + 1);
    localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_TICKS - 1);
    localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_TICKS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W - 1);

    logic              tick;
    logic              tdo_s;
    jbs_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] sh_q, cap_q;
    logic              rd_q;
    logic              accept, low_end, high_end, last_bit, is_pin;

    jbs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    jbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (jtag_tdo),
        .q  (tdo_s)
    );

    assign cmd_ready = (state_q == S_IDLE);
    assign done      = (state_q == S_DONE);
    assign accept    = cmd_valid && cmd_ready;
    assign is_pin    = cmd_op[1];
    assign low_end   = tick && (cnt_q == LOW_LAST);
    assign high_end  = tick && (cnt_q == HIGH_LAST);
    assign last_bit  = (bit_q == LAST_BIT);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // transitions: start/apply, capture+rise, fall/finish, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = is_pin ? S_DONE : S_LOW;
            S_LOW:  if (low_end) state_d = S_HIGH;
            S_HIGH: if (high_end) state_d = last_bit ? S_DONE : S_LOW;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            bit_q     <= '0;
            sh_q      <= '0;
            cap_q     <= '0;
            rd_q      <= 1'b0;
            rsp_data  <= '0;
            rsp_valid <= 1'b0;
            jtag_tck  <= 1'b0;
            jtag_tms  <= 1'b0;
            jtag_tdi  <= 1'b0;
            jtag_oe_n <= 1'b1;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (accept && is_pin) begin
                        jtag_tck  <= cmd_data[PIN_TCK];
                        jtag_tms  <= cmd_data[PIN_TMS];
                        jtag_tdi  <= cmd_data[PIN_TDI];
                        jtag_oe_n <= ~cmd_data[PIN_OE];
                        if (cmd_op[0]) begin
                            rsp_data  <= RB_BASE | {{(BYTE_W-1){1'b0}}, tdo_s};
                            rsp_valid <= 1'b1;
                        end
                    end else if (accept) begin
                        jtag_tck <= 1'b0;
                        sh_q     <= cmd_data;
                        rd_q     <= cmd_op[0];
                        bit_q    <= '0;
                        cnt_q    <= '0;
                    end
                end
                S_LOW: begin
                    if (tick) begin
                        if (cnt_q == '0) begin
                            cap_q    <= {tdo_s, cap_q[BYTE_W-1:1]};
                            jtag_tdi <= sh_q[0];
                            sh_q     <= sh_q >> 1;
                        end
                        if (low_end) begin
                            jtag_tck <= 1'b1;
                            cnt_q    <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                S_HIGH: begin
                    if (high_end) begin
                        jtag_tck <= 1'b0;
                        cnt_q    <= '0;
                        if (last_bit) begin
                            if (rd_q) rsp_data <= cap_q;
                            rsp_valid <= rd_q;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/jbs_checker.sv
module jbs_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic       done,
    input logic       rsp_valid,
    input logic       jtag_tck,
    input logic       jtag_tms,
    input logic       jtag_tdi
);
    logic wo_pending;

    always_ff @(posedge clk) begin
        if (rst)                         wo_pending <= 1'b0;
        else if (cmd_valid && cmd_ready) wo_pending <= (cmd_op == 2'b00);
        else if (done)                   wo_pending <= 1'b0;
    end

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_ready);

    // R5
    rsp_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> done);

    // R6
    wo_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (wo_pending && done) |-> !rsp_valid);

    // R7
    pin_done_next_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == 2'b10) |=> (done && !rsp_valid));

    // R9
    tms_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_ready && cmd_op[1]) |=> $stable(jtag_tms));

    // R3
    tdi_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (jtag_tck && $past(jtag_tck) && !cmd_ready && !done) |-> $stable(jtag_tdi));
endmodule

bind jtag_byte_shifter jbs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op),
    .done     (done),
    .rsp_valid(rsp_valid),
    .jtag_tck (jtag_tck),
    .jtag_tms (jtag_tms),
    .jtag_tdi (jtag_tdi)
);

// File: tb/jtag_byte_shifter_tb.sv
`timescale 1ns/1ps
module jtag_byte_shifter_tb;
    localparam int WD_LIMIT = 150000;
    localparam int NV = 9;
    // {op, data, device byte}
    localparam logic [17:0] VEC [NV] = '{
        {2'b10, 8'h00, 8'h00},
        {2'b11, 8'h33, 8'h01},
        {2'b01, 8'hA5, 8'h3C},
        {2'b00, 8'h5A, 8'hFF},
        {2'b10, 8'h20, 8'h00},
        {2'b01, 8'h01, 8'h80},
        {2'b01, 8'hFF, 8'h00},
        {2'b11, 8'hCE, 8'h00},
        {2'b01, 8'h6D, 8'hD2}
    };

    logic clk = 0, rst = 1;
    logic cmd_valid = 0;
    logic [1:0] cmd_op = 0;
    logic [7:0] cmd_data = 0;
    logic cmd_ready, rsp_valid, done;
    logic [7:0] rsp_data;
    logic jtag_tck, jtag_tms, jtag_tdi, jtag_oe_n;
    logic jtag_tdo = 0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] dev_byte = 0, tdi_seen = 0;
    int rise_cnt = 0, tdi_err = 0, hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, mon_rises = 0;
    logic prev_tck = 0, prev_tdi = 0;

    always #2.5 clk = ~clk;

    jtag_byte_shifter u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_data(rsp_data),
        .rsp_valid(rsp_valid), .done(done), .jtag_tck(jtag_tck),
        .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi), .jtag_oe_n(jtag_oe_n),
        .jtag_tdo(jtag_tdo)
    );

    // device model: records TDI on rise, presents the next TDO bit on fall
    always @(posedge jtag_tck) begin
        if (rise_cnt < 8) tdi_seen[rise_cnt] = jtag_tdi;
        rise_cnt++;
    end
    always @(negedge jtag_tck) begin
        if (rise_cnt > 0 && rise_cnt < 8) jtag_tdo = dev_byte[rise_cnt];
    end

    // phase width and TDI stability monitor
    always @(negedge clk) begin
        if (jtag_tck && !prev_tck) begin
            if (mon_rises > 0) last_lo = lo_run;
            mon_rises++;
            hi_run = 1;
        end else if (jtag_tck) begin
            hi_run++;
            if (prev_tck && jtag_tdi != prev_tdi) tdi_err++;
        end else if (prev_tck) begin
            last_hi = hi_run;
            lo_run = 1;
        end else begin
            lo_run++;
        end
        prev_tck = jtag_tck;
        prev_tdi = jtag_tdi;
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_data = d;
        @(posedge clk);
        #1 cmd_valid = 0;
    endtask

    task automatic wait_done(output logic rv);
        logic seen = 0;
        rv = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (done) begin rv = rsp_valid; seen = 1; break; end
        end
        chk(seen, "R10 done pulse", int'(seen), 1);
    endtask

    task automatic prep(input logic [7:0] dev);
        dev_byte = dev; jtag_tdo = dev[0];
        rise_cnt = 0; tdi_seen = 0; tdi_err = 0; mon_rises = 0;
        last_hi = 0; last_lo = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic rv;
        logic tms_exp;
        logic [7:0] rsp_exp;
        int acc, clash;
        tms_exp = 0; rsp_exp = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk(!jtag_tck && !jtag_tms && !jtag_tdi && jtag_oe_n && cmd_ready && !done,
            "R1 pins in reset", {jtag_tck, jtag_tms, jtag_tdi, jtag_oe_n}, 4'b0001);
        rst = 0;
        @(negedge clk);
        chk(rsp_data == 8'h00 && !rsp_valid && cmd_ready, "R1 after release",
            rsp_data, 0);

        for (int i = 0; i < NV; i++) begin
            automatic logic [1:0] op = VEC[i][17:16];
            automatic logic [7:0] dt = VEC[i][15:8];
            automatic logic [7:0] dv = VEC[i][7:0];
            prep(dv);
            issue(op, dt);
            wait_done(rv);
            if (op[1]) begin
                chk(jtag_tck == dt[0] && jtag_tms == dt[1] && jtag_tdi == dt[4],
                    "R7 pin image", {jtag_tck, jtag_tms, jtag_tdi}, {dt[0], dt[1], dt[4]});
                chk(jtag_oe_n == !dt[5], "R7 oe_n polarity", jtag_oe_n, !dt[5]);
                tms_exp = dt[1];
                if (op[0]) begin
                    chk(rv && rsp_data == (8'h02 | {7'b0, dv[0]}), "R8 readback",
                        rsp_data, 8'h02 | {7'b0, dv[0]});
                    rsp_exp = rsp_data;
                end else begin
                    chk(!rv && rsp_data == rsp_exp, "R7 no response", rsp_data, rsp_exp);
                end
            end else begin
                chk(rise_cnt == 8, "R2 pulse count", rise_cnt, 8);
                chk(tdi_seen == dt, "R2 tdi bits", tdi_seen, dt);
                chk(!jtag_tck && tdi_err == 0, "R3 tck low and tdi held", tdi_err, 0);
                chk(last_hi == 4 && last_lo == 16, "R4 phase widths",
                    last_hi * 256 + last_lo, 4 * 256 + 16);
                chk(jtag_tms == tms_exp, "R9 tms kept", jtag_tms, tms_exp);
                if (op[0]) begin
                    chk(rv && rsp_data == dv, "R5 captured byte", rsp_data, dv);
                    rsp_exp = dv;
                end else begin
                    chk(!rv && rsp_data == rsp_exp, "R6 write-only ignores tdo",
                        rsp_data, rsp_exp);
                end
            end
        end

        // R10/R9: pin command waiting while a shift completes
        prep(8'hF0);
        issue(2'b01, 8'h0F);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b10; cmd_data = 8'h00;
        wait_done(rv);
        chk(!cmd_ready && jtag_tms == tms_exp && rsp_data == 8'hF0,
            "R10 busy at done", {cmd_ready, jtag_tms}, {1'b0, tms_exp});
        @(negedge clk);
        chk(cmd_ready && jtag_tms == tms_exp, "R10 ready after done", cmd_ready, 1);
        @(negedge clk);
        chk(done && !cmd_ready && jtag_tms == 1'b0, "R9 tms after pin accept",
            jtag_tms, 0);

        // R10: held valid gives one acceptance per two cycles
        acc = 0; clash = 0;
        for (int k = 0; k < 20; k++) begin
            if (cmd_valid && cmd_ready) acc++;
            if (done && cmd_ready) clash++;
            @(negedge clk);
        end
        cmd_valid = 0;
        chk(acc == 10, "R10 acceptance rate", acc, 10);
        chk(clash == 0, "R10 done excludes ready", clash, 0);

        // R1: reset mid-shift
        issue(2'b00, 8'hFF);
        repeat (30) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!jtag_tck && !jtag_tms && !jtag_tdi && jtag_oe_n && cmd_ready && rsp_data == 0,
            "R1 reset mid-shift", {jtag_tck, jtag_tdi, jtag_oe_n}, 3'b001);

        summary();
        $finish;
    end
endmodule